// File: doc/BRIEF.md
# Paired Vector Register Load Unit

This unit decodes and executes one instruction form: a load of two vector/floating-point registers with a non-temporal hint. It takes a 32-bit instruction word through a valid/ready handshake. It reads a base value, either a general-purpose register or the stack pointer. It adds a scaled, sign-extended 7-bit immediate to that base. It then issues a single memory read that covers both destination registers. When the read data returns, the unit splits it into two register-file writes. The halves are ordered by the endianness that was in force when the instruction was accepted.

A two-bit size field picks the element width (32, 64 or 128 bits). The same field also sets the scale applied to the immediate. An instruction that does not decode raises an undefined flag. So does a reserved size, and so does a destination-number clash under some policies. A clash can instead raise a no-operation flag, or load while writing a fixed filler value, depending on a policy input. A misaligned stack-pointer base raises an alignment fault. Every such outcome takes no memory access.

The controller is a four-state machine:
- ST_IDLE accepts an instruction.
- ST_ISSUE holds the read request until the memory takes it.
- ST_WAIT waits for the response and writes both registers in the cycle the response is taken.
- ST_REPORT pulses one outcome flag for a single cycle.

The transitions are:
- IDLE→ISSUE on an accepted, valid load.
- IDLE→REPORT on an accepted instruction that ends as undefined, no-operation or fault.
- ISSUE→WAIT when the request is taken.
- WAIT→IDLE when the response is taken.
- REPORT→IDLE always.

Top module: `vpair_ld_unit`

## Requirements
- R1: An instruction whose bits 29:22 differ from 8'b1011_0001 raises `undef_o` and makes no memory request. The fields are: size = bits 31:30, imm7 = bits 21:15, second target = bits 14:10, base = bits 9:5, first target = bits 4:0.
- R2: Size 2'b11 raises `undef_o` and makes no memory request. Sizes 00, 01 and 10 select 32-, 64- and 128-bit elements.
- R3: The request address equals base + (sign-extended imm7 << (2+size)), computed modulo 2^64. The base is `sp_value` when the base field is 31, and `gpr_data` for `gpr_idx` otherwise.
- R4: The request carries the following attributes:
  - `mem_req_lg2bytes` = 3+size;
  - `mem_req_nontemp` = 1;
  - `mem_req_pair` = 1;
  - `mem_req_tagchk` = 1 exactly when the base field is not 31;
  - `mem_req_priv` = 1 exactly when the captured `cur_el` is nonzero.
- R5: With base field 31 and `sp_value[3:0]` nonzero, the unit raises `sp_fault_o` and makes no request. Undefined and no-operation outcomes take priority over this fault.
- R6: In little-endian mode, `wr0_data` receives the low element of the response and `wr1_data` the next element. Both are zero above the element width.
- R7: In big-endian mode (`big_endian`=1 at acceptance), the halves are swapped. `wr1_data` takes the low element and `wr0_data` the high element.
- R8: When both target numbers are equal and `clash_policy`=2'b00, the read is still made. On the response only `wr0_en` pulses, carrying `ARB_FILL`.
- R9: When both target numbers are equal, `clash_policy` 2'b01 and 2'b11 raise `undef_o`, and 2'b10 raises `nop_o`. Neither makes a request.
- R10: `insn_ready` is low from acceptance until the load or report completes. An unaccepted request keeps its valid and address stable. `wr0_en`/`wr1_en` are high only in the cycle `mem_rsp_valid` and `mem_rsp_ready` are both high.
- R11: After reset, and between instructions, `insn_ready`=1 and no request, write enable or flag is active. Each outcome flag lasts exactly one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| insn_valid | input | 1 | Instruction word offered |
| insn_word | input | 32 | Instruction word |
| insn_ready | output | 1 | Unit can take an instruction |
| big_endian | input | 1 | Data endianness, captured at acceptance |
| clash_policy | input | 2 | Equal-target outcome: 00 filler load, 01/11 undefined, 10 no-op |
| cur_el | input | 2 | Current exception level, captured at acceptance |
| gpr_idx | output | 5 | General register read index (base field) |
| gpr_data | input | 64 | General register read data |
| sp_value | input | 64 | Stack pointer value |
| mem_req_valid | output | 1 | Read request valid |
| mem_req_ready | input | 1 | Memory takes the request |
| mem_req_addr | output | 64 | Read byte address |
| mem_req_lg2bytes | output | 3 | log2 of bytes read |
| mem_req_nontemp | output | 1 | Non-temporal hint |
| mem_req_pair | output | 1 | Pair access marker |
| mem_req_tagchk | output | 1 | Tag checking enabled |
| mem_req_priv | output | 1 | Privileged access |
| mem_rsp_valid | input | 1 | Read response valid |
| mem_rsp_ready | output | 1 | Unit takes the response |
| mem_rsp_data | input | 256 | Read data, lowest address in low bits |
| wr0_en | output | 1 | First target write enable |
| wr0_idx | output | 5 | First target register number |
| wr0_data | output | 128 | First target write data |
| wr1_en | output | 1 | Second target write enable |
| wr1_idx | output | 5 | Second target register number |
| wr1_data | output | 128 | Second target write data |
| undef_o | output | 1 | Undefined-instruction pulse |
| nop_o | output | 1 | No-operation pulse |
| sp_fault_o | output | 1 | Stack alignment fault pulse |

## Verification
An accepted instruction shows its outcome one clock after the accepting edge. That outcome is either the request on the memory port or a single outcome flag, and the bench samples it at the following falling edge. The request is re-checked at each falling edge for as long as `mem_req_ready` is withheld. The register writes are combinational on the response handshake, so the bench raises `mem_rsp_valid` at a falling edge and checks the write ports a moment later, before the next rising edge. One cycle after that edge, the bench confirms that enables and flags are gone and `insn_ready` is back.

// File: rtl/vpl_pkg.sv
package vpl_pkg;

    localparam logic [7:0] VPL_KEY   = 8'b1011_0001;
    localparam int         VPL_NSIZE = 3;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_ISSUE  = 2'd1,
        ST_WAIT   = 2'd2,
        ST_REPORT = 2'd3
    } vpl_state_e;

    typedef enum logic [1:0] {
        POL_FILL  = 2'd0,
        POL_UNDEF = 2'd1,
        POL_NOP   = 2'd2,
        POL_RSV   = 2'd3
    } vpl_policy_e;

    typedef struct packed {
        logic [1:0] size;
        logic [6:0] imm7;
        logic [4:0] tgt_b;
        logic [4:0] base;
        logic [4:0] tgt_a;
    } vpl_fields_t;

endpackage

// File: rtl/vpl_decode.sv
module vpl_decode
    import vpl_pkg::*;
(
    input  logic [31:0] insn,
    output vpl_fields_t fields,
    output logic        bad_form,
    output logic        clash
);
    always_comb begin
        fields.size  = insn[31:30];
        fields.imm7  = insn[21:15];
        fields.tgt_b = insn[14:10];
        fields.base  = insn[9:5];
        fields.tgt_a = insn[4:0];
        bad_form     = (insn[29:22] != VPL_KEY) || (insn[31:30] == 2'b11);
        clash        = (insn[14:10] == insn[4:0]);
    end
endmodule

// File: rtl/vpl_agen.sv
module vpl_agen #(
    parameter int XLEN = 64
) (
    input  logic [XLEN-1:0] base_val,
    input  logic [6:0]      imm7,
    input  logic [1:0]      size,
    output logic [XLEN-1:0] addr
);
    localparam int SCALE_W = 3;

    logic [XLEN-1:0]    imm_ext;
    logic [SCALE_W-1:0] scale;

    always_comb begin
        imm_ext = {{(XLEN-7){imm7[6]}}, imm7};
        scale   = SCALE_W'(size) + SCALE_W'(2);
        addr    = base_val + (imm_ext << scale);
    end
endmodule

// File: rtl/vpl_split.sv
module vpl_split
    import vpl_pkg::*;
#(
    parameter int VLEN = 128
) (
    input  logic [2*VLEN-1:0] rsp,
    input  logic [1:0]        size,
    input  logic              be,
    output logic [VLEN-1:0]   first,
    output logic [VLEN-1:0]   second
);
    logic [VLEN-1:0] cand_lo [VPL_NSIZE];
    logic [VLEN-1:0] cand_hi [VPL_NSIZE];

    for (genvar k = 0; k < VPL_NSIZE; k++) begin : g_sz
        localparam int W = 32 << k;
        always_comb begin
            cand_lo[k]        = '0;
            cand_hi[k]        = '0;
            cand_lo[k][W-1:0] = rsp[W-1:0];
            cand_hi[k][W-1:0] = rsp[2*W-1:W];
        end
    end

    always_comb begin
        first  = '0;
        second = '0;
        if (int'(size) < VPL_NSIZE) begin
            first  = be ? cand_hi[size] : cand_lo[size];
            second = be ? cand_lo[size] : cand_hi[size];
        end
    end
endmodule

// File: rtl/vpair_ld_unit.sv
module vpair_ld_unit
    import vpl_pkg::*;
#(
    parameter int              XLEN     = 64,
    parameter int              VLEN     = 128,
    parameter int              SP_ALN   = 4,
    parameter logic [VLEN-1:0] ARB_FILL = {(VLEN/32){32'hBAD0_F00D}}
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              insn_valid,
    input  logic [31:0]       insn_word,
    output logic              insn_ready,
    input  logic              big_endian,
    input  logic [1:0]        clash_policy,
    input  logic [1:0]        cur_el,
    output logic [4:0]        gpr_idx,
    input  logic [XLEN-1:0]   gpr_data,
    input  logic [XLEN-1:0]   sp_value,
    output logic              mem_req_valid,
    input  logic              mem_req_ready,
    output logic [XLEN-1:0]   mem_req_addr,
    output logic [2:0]        mem_req_lg2bytes,
    output logic              mem_req_nontemp,
    output logic              mem_req_pair,
    output logic              mem_req_tagchk,
    output logic              mem_req_priv,
    input  logic              mem_rsp_valid,
    output logic              mem_rsp_ready,
    input  logic [2*VLEN-1:0] mem_rsp_data,
    output logic              wr0_en,
    output logic [4:0]        wr0_idx,
    output logic [VLEN-1:0]   wr0_data,
    output logic              wr1_en,
    output logic [4:0]        wr1_idx,
    output logic [VLEN-1:0]   wr1_data,
    output logic              undef_o,
    output logic              nop_o,
    output logic              sp_fault_o
);
    localparam logic [4:0] SP_NUM = 5'd31;

    vpl_state_e  st_q, st_n;
    vpl_fields_t fld;
    logic        bad_form, clash;
    logic [XLEN-1:0] base_val, addr_n;
    logic [VLEN-1:0] split_a, split_b;

    logic [XLEN-1:0] addr_q;
    logic [1:0]      size_q;
    logic [4:0]      tgt_a_q, tgt_b_q;
    logic            be_q, fill_q, tag_q, priv_q;
    logic            f_undef_q, f_nop_q, f_fault_q;

    logic accept, sp_bad, go_undef, go_nop, go_fault, go_issue;

    vpl_decode u_dec (
        .insn     (insn_word),
        .fields   (fld),
        .bad_form (bad_form),
        .clash    (clash)
    );

    vpl_agen #(.XLEN(XLEN)) u_agen (
        .base_val (base_val),
        .imm7     (fld.imm7),
        .size     (fld.size),
        .addr     (addr_n)
    );

    vpl_split #(.VLEN(VLEN)) u_split (
        .rsp    (mem_rsp_data),
        .size   (size_q),
        .be     (be_q),
        .first  (split_a),
        .second (split_b)
    );

    // Outcome selection for the offered instruction.
    always_comb begin
        accept   = (st_q == ST_IDLE) && insn_valid;
        gpr_idx  = fld.base;
        base_val = (fld.base == SP_NUM) ? sp_value : gpr_data;
        sp_bad   = (fld.base == SP_NUM) && (sp_value[SP_ALN-1:0] != '0);
        go_undef = bad_form ||
                   (clash && (clash_policy == POL_UNDEF || clash_policy == POL_RSV));
        go_nop   = !go_undef && clash && (clash_policy == POL_NOP);
        go_fault = !go_undef && !go_nop && sp_bad;
        go_issue = !go_undef && !go_nop && !sp_bad;
    end

    // Next-state logic.
    always_comb begin
        st_n = st_q;
        unique case (st_q)
            ST_IDLE:   if (accept) st_n = go_issue ? ST_ISSUE : ST_REPORT;
            ST_ISSUE:  if (mem_req_ready) st_n = ST_WAIT;
            ST_WAIT:   if (mem_rsp_valid) st_n = ST_IDLE;
            ST_REPORT: st_n = ST_IDLE;
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= ST_IDLE;
        else        st_q <= st_n;
    end

    // Per-instruction capture.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q    <= '0;
            size_q    <= '0;
            tgt_a_q   <= '0;
            tgt_b_q   <= '0;
            be_q      <= 1'b0;
            fill_q    <= 1'b0;
            tag_q     <= 1'b0;
            priv_q    <= 1'b0;
            f_undef_q <= 1'b0;
            f_nop_q   <= 1'b0;
            f_fault_q <= 1'b0;
        end else if (accept) begin
            addr_q    <= addr_n;
            size_q    <= fld.size;
            tgt_a_q   <= fld.tgt_a;
            tgt_b_q   <= fld.tgt_b;
            be_q      <= big_endian;
            fill_q    <= clash && (clash_policy == POL_FILL);
            tag_q     <= (fld.base != SP_NUM);
            priv_q    <= (cur_el != 2'd0);
            f_undef_q <= go_undef;
            f_nop_q   <= go_nop;
            f_fault_q <= go_fault;
        end
    end

    // Outputs.
    always_comb begin
        insn_ready       = (st_q == ST_IDLE);
        mem_req_valid    = (st_q == ST_ISSUE);
        mem_req_addr     = addr_q;
        mem_req_lg2bytes = 3'(size_q) + 3'd3;
        mem_req_nontemp  = 1'b1;
        mem_req_pair     = 1'b1;
        mem_req_tagchk   = tag_q;
        mem_req_priv     = priv_q;
        mem_rsp_ready    = (st_q == ST_WAIT);
        wr0_en           = (st_q == ST_WAIT) && mem_rsp_valid;
        wr1_en           = wr0_en && !fill_q;
        wr0_idx          = tgt_a_q;
        wr1_idx          = tgt_b_q;
        wr0_data         = fill_q ? ARB_FILL : split_a;
        wr1_data         = split_b;
        undef_o          = (st_q == ST_REPORT) && f_undef_q;
        nop_o            = (st_q == ST_REPORT) && f_nop_q;
        sp_fault_o       = (st_q == ST_REPORT) && f_fault_q;
    end

    // Assertions
    p_req_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid && !mem_req_ready |=> mem_req_valid && $stable(mem_req_addr));

    p_wr_on_rsp_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (wr0_en || wr1_en) |-> (mem_rsp_valid && mem_rsp_ready));

    p_busy_no_take_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_valid || mem_rsp_ready) |-> !insn_ready);

    p_flag_single_r11: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({undef_o, nop_o, sp_fault_o}));

    p_flag_pulse_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (undef_o || nop_o || sp_fault_o) |=> !(undef_o || nop_o || sp_fault_o));

    p_flag_no_req_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (undef_o || nop_o || sp_fault_o) |-> !mem_req_valid && !wr0_en);

    p_fill_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
        wr1_en |-> wr0_en && (wr0_idx != wr1_idx || !wr0_en));
endmodule

// File: tb/vpair_ld_unit_tb.sv
module vpair_ld_unit_tb_top;
    localparam int TCLK = 10;
    localparam logic [127:0] FILL = {4{32'hBAD0_F00D}};

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         insn_valid = 1'b0;
    logic [31:0]  insn_word = '0;
    logic         insn_ready;
    logic         big_endian = 1'b0;
    logic [1:0]   clash_policy = 2'd0;
    logic [1:0]   cur_el = 2'd0;
    logic [4:0]   gpr_idx;
    logic [63:0]  gpr_data;
    logic [63:0]  sp_value = '0;
    logic         mem_req_valid, mem_req_ready = 1'b0;
    logic [63:0]  mem_req_addr;
    logic [2:0]   mem_req_lg2bytes;
    logic         mem_req_nontemp, mem_req_pair, mem_req_tagchk, mem_req_priv;
    logic         mem_rsp_valid = 1'b0, mem_rsp_ready;
    logic [255:0] mem_rsp_data = '0;
    logic         wr0_en, wr1_en;
    logic [4:0]   wr0_idx, wr1_idx;
    logic [127:0] wr0_data, wr1_data;
    logic         undef_o, nop_o, sp_fault_o;

    int unsigned n_chk = 0, n_bad = 0;

    always #(TCLK/2) clk = ~clk;

    function automatic logic [63:0] gpr_fn(input logic [4:0] i);
        return 64'h0000_4000_0000_0000 + {27'd0, i, 32'h0011_0230};
    endfunction
    assign gpr_data = gpr_fn(gpr_idx);

    vpair_ld_unit dut_i (.*);

    task automatic chk(input bit ok, input string tag, input logic [255:0] act, input logic [255:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    task automatic run_one(input logic [31:0] w, input bit be, input logic [1:0] pol,
                           input logic [1:0] el, input logic [63:0] spv,
                           input logic [255:0] rsp, input int rdly, input int pdly);
        logic [1:0]   sz;
        logic [4:0]   rn, ta, tb;
        bit           key, clash, e_undef, e_nop, e_fault, fill;
        logic [63:0]  base, eaddr, off;
        logic [255:0] mask;
        logic [127:0] lo, hi, e0, e1;
        int           wd;
        sz = w[31:30]; rn = w[9:5]; ta = w[4:0]; tb = w[14:10];
        key = (w[29:22] == 8'b1011_0001);
        clash = (ta == tb);
        e_undef = !key || sz == 2'b11 || (clash && (pol == 2'd1 || pol == 2'd3));
        e_nop = !e_undef && clash && pol == 2'd2;
        e_fault = !e_undef && !e_nop && rn == 5'd31 && spv[3:0] != 4'd0;
        fill = clash && pol == 2'd0;
        base = (rn == 5'd31) ? spv : gpr_fn(rn);
        off = {{57{w[21]}}, w[21:15]} << (sz + 2);
        eaddr = base + off;

        @(negedge clk);
        while (!insn_ready) @(negedge clk);
        insn_word = w; insn_valid = 1'b1; big_endian = be; clash_policy = pol;
        cur_el = el; sp_value = spv;
        @(posedge clk); #1;
        insn_valid = 1'b0;
        @(negedge clk);
        chk(insn_ready == 1'b0, "R10 busy after accept", 256'(insn_ready), 0);
        if (e_undef || e_nop || e_fault) begin
            chk(undef_o == e_undef, (!key || sz == 2'b11) ? "R1/R2 undef flag" : "R9 undef flag",
                256'(undef_o), 256'(e_undef));
            chk(nop_o == e_nop, "R9 nop flag", 256'(nop_o), 256'(e_nop));
            chk(sp_fault_o == e_fault, "R5 sp fault flag", 256'(sp_fault_o), 256'(e_fault));
            chk(mem_req_valid == 1'b0, "R5 no request on flag", 256'(mem_req_valid), 0);
            @(negedge clk);
            chk({undef_o, nop_o, sp_fault_o} == 3'b000 && insn_ready,
                "R11 flag lasts one cycle", 256'({undef_o, nop_o, sp_fault_o, insn_ready}), 256'(1));
        end else begin
            chk({undef_o, nop_o, sp_fault_o} == 3'b000, "R11 no flag on load",
                256'({undef_o, nop_o, sp_fault_o}), 0);
            chk(mem_req_valid && mem_req_addr == eaddr, "R3 address", 256'(mem_req_addr), 256'(eaddr));
            chk(mem_req_lg2bytes == 3'(sz) + 3'd3 && mem_req_nontemp && mem_req_pair &&
                mem_req_tagchk == (rn != 5'd31) && mem_req_priv == (el != 2'd0),
                "R4 attributes",
                256'({mem_req_lg2bytes, mem_req_nontemp, mem_req_pair, mem_req_tagchk, mem_req_priv}),
                256'({3'(sz) + 3'd3, 1'b1, 1'b1, rn != 5'd31, el != 2'd0}));
            for (int d = 0; d < rdly; d++) begin
                @(negedge clk);
                chk(mem_req_valid && mem_req_addr == eaddr && !insn_ready, "R10 request held",
                    256'(mem_req_addr), 256'(eaddr));
            end
            mem_req_ready = 1'b1;
            @(posedge clk); #1;
            mem_req_ready = 1'b0;
            for (int d = 0; d < pdly; d++) begin
                @(negedge clk);
                chk(!wr0_en && !wr1_en && !mem_req_valid, "R10 no write before response",
                    256'({wr0_en, wr1_en, mem_req_valid}), 0);
            end
            @(negedge clk);
            mem_rsp_data = rsp; mem_rsp_valid = 1'b1;
            #1;
            wd = 32 << sz;
            mask = (256'd1 << wd) - 256'd1;
            lo = 128'(rsp & mask);
            hi = 128'((rsp >> wd) & mask);
            e0 = fill ? FILL : (be ? hi : lo);
            e1 = be ? lo : hi;
            chk(mem_rsp_ready && wr0_en && wr0_idx == ta, "R10 first write on response",
                256'({mem_rsp_ready, wr0_en, wr0_idx}), 256'({1'b1, 1'b1, ta}));
            if (fill) begin
                chk(wr0_data == FILL, "R8 filler value", 256'(wr0_data), 256'(FILL));
                chk(!wr1_en, "R8 second write suppressed", 256'(wr1_en), 0);
            end else begin
                chk(wr0_data == e0, be ? "R7 first target data" : "R6 first target data",
                    256'(wr0_data), 256'(e0));
                chk(wr1_en && wr1_idx == tb && wr1_data == e1,
                    be ? "R7 second target data" : "R6 second target data",
                    256'(wr1_data), 256'(e1));
            end
            @(posedge clk); #1;
            mem_rsp_valid = 1'b0;
            @(negedge clk);
            chk(!wr0_en && !wr1_en && insn_ready, "R11 idle after load",
                256'({wr0_en, wr1_en, insn_ready}), 256'(1));
        end
    endtask

    function automatic logic [31:0] mk(input logic [1:0] sz, input logic [6:0] imm,
                                        input logic [4:0] b, input logic [4:0] rn, input logic [4:0] a);
        return {sz, 8'b1011_0001, imm, b, rn, a};
    endfunction

    initial begin
        repeat (150000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog expired act=1 exp=0");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        logic [255:0] rd;
        logic [31:0]  w;
        logic [63:0]  spv;
        int unsigned  seed;
        seed = 32'd20240611;
        void'($urandom(seed));
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk(insn_ready && !mem_req_valid && !wr0_en && !wr1_en &&
            {undef_o, nop_o, sp_fault_o} == 3'b000, "R11 reset state",
            256'({insn_ready, mem_req_valid, wr0_en, wr1_en, undef_o, nop_o, sp_fault_o}),
            256'(7'b1000000));
        rst_n = 1'b1;
        rd = {64'hF0F1F2F3F4F5F6F7, 64'hE0E1E2E3E4E5E6E7, 64'hD0D1D2D3D4D5D6D7, 64'hC0C1C2C3C4C5C6C7};
        // Directed corners.
        run_one(mk(2'b00, 7'h40, 5'd2, 5'd3, 5'd1), 0, 0, 0, 0, rd, 0, 0);         // R6 R3 min imm
        run_one(mk(2'b01, 7'h3F, 5'd7, 5'd4, 5'd6), 1, 0, 1, 0, rd, 2, 1);         // R7 max imm
        run_one(mk(2'b10, 7'h7F, 5'd9, 5'd31, 5'd8), 0, 0, 3, 64'h8000, rd, 1, 0);  // R3 sp base
        run_one(mk(2'b10, 7'h01, 5'd9, 5'd31, 5'd8), 1, 0, 0, 64'h8004, rd, 0, 0);  // R5
        run_one(mk(2'b11, 7'h01, 5'd9, 5'd2, 5'd8), 0, 0, 0, 0, rd, 0, 0);         // R2
        run_one(32'hFFFF_FFFF, 0, 0, 0, 0, rd, 0, 0);                              // R1
        run_one(mk(2'b01, 7'h05, 5'd5, 5'd1, 5'd5), 0, 2'd0, 0, 0, rd, 0, 2);      // R8
        run_one(mk(2'b01, 7'h05, 5'd5, 5'd1, 5'd5), 0, 2'd1, 0, 0, rd, 0, 0);      // R9 undef
        run_one(mk(2'b01, 7'h05, 5'd5, 5'd1, 5'd5), 0, 2'd2, 0, 0, rd, 0, 0);      // R9 nop
        run_one(mk(2'b01, 7'h05, 5'd5, 5'd1, 5'd5), 0, 2'd3, 0, 0, rd, 0, 0);      // R9 reserved
        run_one(mk(2'b00, 7'h05, 5'd5, 5'd31, 5'd5), 0, 2'd2, 0, 64'h3, rd, 0, 0); // R5 priority
        // Random mix.
        for (int i = 0; i < 400; i++) begin
            w = $urandom;
            if ($urandom_range(9) != 0) w[29:22] = 8'b1011_0001;
            if ($urandom_range(3) == 0) w[9:5] = 5'd31;
            if ($urandom_range(4) == 0) w[14:10] = w[4:0];
            spv = {$urandom, $urandom};
            if ($urandom_range(3) != 0) spv[3:0] = 4'd0;
            rd = {$urandom, $urandom, $urandom, $urandom, $urandom, $urandom, $urandom, $urandom};
            run_one(w, 1'($urandom), 2'($urandom), 2'($urandom), spv, rd,
                    int'($urandom_range(3)), int'($urandom_range(2)));
        end
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule